// File: doc/BRIEF.md
# Port Access Strobe Generator

This block is an 8-bit general-purpose I/O port with a handshake option for an on-chip processor. The processor reaches it through a small register interface: an address, a write enable, a read enable, write data and registered read data. Behind that interface sit the port output register, a per-bit direction register and a control register. Bit 0 of the control register turns the strobe option on.

While the option is on, every processor write to the port data register produces an active-low write strobe. The strobe follows a fixed delay after the write. Every processor read of the port data register produces an active-low read strobe, also after a fixed delay. External logic treats the read strobe as a prefetch cue only. The byte the processor received was captured in the access cycle itself, before the strobe asserts, so the external logic may drive the next byte once it sees the strobe. The pin input passes through a two-flop synchronizer, and all read timing is measured from its output.

Each strobe has its own sequencer, an enumerated machine with three states. IDLE holds the strobe high. DELAY counts clock edges after an access. ACTIVE holds the strobe low for a fixed number of cycles. The transitions are:
- IDLE→DELAY on a qualifying access.
- DELAY→ACTIVE when the delay count is reached.
- ACTIVE→IDLE when the width count is reached.
- Any state→DELAY on a new qualifying access, which restarts the sequence.
- Any state→IDLE whenever the enable bit is clear.

Top module: `port_strobe_gen`

## Requirements
- R1: During synchronous reset (`rst` high), after the next edge `rd_n` and `wr_n` are 1, `pin_out` is 0, `pin_oe` is 0 (all bits inputs), `cpu_rdata` is 0 and the enable bit is 0.
- R2: While control bit 0 (address 2) is 0, port accesses produce no strobe. If the bit is cleared while a sequence is running, both strobes are high from the edge after the clearing edge onward. An access qualifies only if the bit was already 1 before the access edge.
- R3: A write to address 0 loads `pin_out` on the same edge. A write to address 1 loads `pin_oe` on the same edge, where 1 means output.
- R4: After a qualifying write to address 0 sampled at edge E0, `wr_n` is low after edges E2 and E3, and it is high again after E4.
- R5: After a qualifying read of address 0 sampled at edge E0, `rd_n` is low after edges E3 and E4, and it is high again after E5.
- R6: A read of address 0 at edge E0 returns in `cpu_rdata` the synchronized input, which is the `pin_in` value sampled at edge E-2. `cpu_rdata` changes only on a processor read, and the read strobe causes no new sampling.
- R7: A qualifying access of one strobe type that arrives while that strobe's sequence is in progress restarts its delay from the new access edge.
- R8: The read and write sequencers run independently. A simultaneous read and write of address 0 yields both strobes, each with its own timing.
- R9: A read of address 1 returns the direction register. A read of address 2 returns the enable bit in bit 0 and zeros elsewhere. A read of address 3 returns 0. No access to addresses 1, 2 or 3 produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts its rising edges |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 2 | Register select: 0 port data, 1 direction, 2 control, 3 unused |
| cpu_wr_en | input | 1 | Processor write enable |
| cpu_rd_en | input | 1 | Processor read enable |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered processor read data |
| pin_in | input | 8 | Port pin input, asynchronous |
| pin_out | output | 8 | Port output register |
| pin_oe | output | 8 | Per-bit output enable, 1 means drive |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bound checker tracks each strobe against an age counter that it keeps from the access enables and the enable bit. This lets it check on every cycle the exact strobe window, the restart on retrigger and the forced-high state when the enable bit is clear. It also checks the reset values and the same-edge load of `pin_out` on every cycle. The timing of the synchronizer and the captured read value, the register readback on addresses 1 to 3, and the fact that the read strobe leaves `cpu_rdata` unchanged while the pins move are shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/psg_pkg.sv
package psg_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DELAY  = 2'd1,
        SEQ_ACTIVE = 2'd2
    } seq_state_t;

    localparam int          ADDR_W    = 2;
    localparam logic [1:0]  ADDR_PORT = 2'd0;
    localparam logic [1:0]  ADDR_DIR  = 2'd1;
    localparam logic [1:0]  ADDR_CTRL = 2'd2;
    localparam int          CTRL_EN_BIT = 0;

endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/psg_strobe_seq.sv
module psg_strobe_seq
    import psg_pkg::*;
#(
    parameter int DELAY = 2,
    parameter int WIDTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trigger,
    output logic strobe_n
);

    localparam int MAXC = (DELAY > WIDTH) ? DELAY : WIDTH;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_C = CW'(DELAY);
    localparam logic [CW-1:0] WID_C = CW'(WIDTH);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    seq_state_t    state_q, state_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          strobe_n_q;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        if (!enable) begin
            state_nxt = SEQ_IDLE;
            cnt_nxt   = '0;
        end else if (trigger) begin
            state_nxt = SEQ_DELAY;
            cnt_nxt   = ONE_C;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_nxt = '0;
                end
                SEQ_DELAY: begin
                    if (cnt_q == DLY_C) begin
                        state_nxt = SEQ_ACTIVE;
                        cnt_nxt   = ONE_C;
                    end else begin
                        cnt_nxt = cnt_q + ONE_C;
                    end
                end
                SEQ_ACTIVE: begin
                    if (cnt_q == WID_C) begin
                        state_nxt = SEQ_IDLE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt_q + ONE_C;
                    end
                end
                default: begin
                    state_nxt = SEQ_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // registered output
    always_ff @(posedge clk) begin
        if (rst) strobe_n_q <= 1'b1;
        else     strobe_n_q <= (state_nxt != SEQ_ACTIVE);
    end

    assign strobe_n = strobe_n_q;

endmodule

// File: rtl/psg_regfile.sv
module psg_regfile
    import psg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [DW-1:0]     sync_in,
    output logic [DW-1:0]     cpu_rdata,
    output logic [DW-1:0]     port_out,
    output logic [DW-1:0]     port_oe,
    output logic              strobe_en,
    output logic              port_wr_hit,
    output logic              port_rd_hit
);

    logic [DW-1:0] out_q, oe_q, rdata_q;
    logic          en_q;

    assign port_wr_hit = cpu_wr_en && (cpu_addr == ADDR_PORT);
    assign port_rd_hit = cpu_rd_en && (cpu_addr == ADDR_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
            en_q  <= 1'b0;
        end else if (cpu_wr_en) begin
            unique case (cpu_addr)
                ADDR_PORT: out_q <= cpu_wdata;
                ADDR_DIR:  oe_q  <= cpu_wdata;
                ADDR_CTRL: en_q  <= cpu_wdata[CTRL_EN_BIT];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cpu_rd_en) begin
            unique case (cpu_addr)
                ADDR_PORT: rdata_q <= sync_in;
                ADDR_DIR:  rdata_q <= oe_q;
                ADDR_CTRL: rdata_q <= {{(DW-1){1'b0}}, en_q};
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign cpu_rdata = rdata_q;
    assign port_out  = out_q;
    assign port_oe   = oe_q;
    assign strobe_en = en_q;

endmodule

// File: rtl/port_strobe_gen.sv
module port_strobe_gen
    import psg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int WR_DELAY  = 2,
    parameter int RD_DELAY  = 3,
    parameter int STB_WIDTH = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic [DW-1:0]     pin_in,
    output logic [DW-1:0]     pin_out,
    output logic [DW-1:0]     pin_oe,
    output logic              rd_n,
    output logic              wr_n
);

    logic [DW-1:0] pin_sync;
    logic          strobe_en;
    logic          port_wr_hit, port_rd_hit;
    logic          wr_trig, rd_trig;

    psg_sync #(.WIDTH(DW), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    psg_regfile #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_rd_en   (cpu_rd_en),
        .cpu_wdata   (cpu_wdata),
        .sync_in     (pin_sync),
        .cpu_rdata   (cpu_rdata),
        .port_out    (pin_out),
        .port_oe     (pin_oe),
        .strobe_en   (strobe_en),
        .port_wr_hit (port_wr_hit),
        .port_rd_hit (port_rd_hit)
    );

    // qualify with the enable value held before the access edge
    assign wr_trig = port_wr_hit && strobe_en;
    assign rd_trig = port_rd_hit && strobe_en;

    psg_strobe_seq #(.DELAY(WR_DELAY), .WIDTH(STB_WIDTH)) u_wr_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (strobe_en),
        .trigger  (wr_trig),
        .strobe_n (wr_n)
    );

    psg_strobe_seq #(.DELAY(RD_DELAY), .WIDTH(STB_WIDTH)) u_rd_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (strobe_en),
        .trigger  (rd_trig),
        .strobe_n (rd_n)
    );

endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
    parameter int DW        = 8,
    parameter int WR_DELAY  = 2,
    parameter int RD_DELAY  = 3,
    parameter int STB_WIDTH = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cpu_addr,
    input logic          cpu_wr_en,
    input logic          cpu_rd_en,
    input logic [DW-1:0] cpu_wdata,
    input logic [DW-1:0] pin_out,
    input logic [DW-1:0] pin_oe,
    input logic          strobe_en,
    input logic          rd_n,
    input logic          wr_n
);

    localparam int W_SAT = WR_DELAY + STB_WIDTH;
    localparam int R_SAT = RD_DELAY + STB_WIDTH;

    int w_age, r_age;
    logic w_acc, r_acc;

    assign w_acc = cpu_wr_en && (cpu_addr == 2'd0);
    assign r_acc = cpu_rd_en && (cpu_addr == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            w_age <= W_SAT;
            r_age <= R_SAT;
        end else begin
            if (w_acc && strobe_en)  w_age <= 0;
            else if (!strobe_en)     w_age <= W_SAT;
            else if (w_age < W_SAT)  w_age <= w_age + 1;
            if (r_acc && strobe_en)  r_age <= 0;
            else if (!strobe_en)     r_age <= R_SAT;
            else if (r_age < R_SAT)  r_age <= r_age + 1;
        end
    end

    assert_reset_values_R1: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && pin_out == '0 && pin_oe == '0 && !strobe_en));

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !strobe_en |=> (rd_n && wr_n));

    assert_port_load_R3: assert property (@(posedge clk) disable iff (rst)
        w_acc |=> (pin_out == $past(cpu_wdata)));

    assert_wr_window_R4: assert property (@(posedge clk) disable iff (rst)
        wr_n == !(w_age >= WR_DELAY && w_age < W_SAT));

    assert_rd_window_R5: assert property (@(posedge clk) disable iff (rst)
        rd_n == !(r_age >= RD_DELAY && r_age < R_SAT));

    // R7: a new write access always returns the write strobe high next cycle
    assert_wr_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (w_acc && strobe_en) |=> wr_n);

endmodule

bind port_strobe_gen psg_checker #(
    .DW(DW), .WR_DELAY(WR_DELAY), .RD_DELAY(RD_DELAY), .STB_WIDTH(STB_WIDTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr_en (cpu_wr_en),
    .cpu_rd_en (cpu_rd_en),
    .cpu_wdata (cpu_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .strobe_en (strobe_en),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/port_strobe_gen_tb.sv
module port_strobe_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_addr = '0;
    logic       cpu_wr_en = 1'b0;
    logic       cpu_rd_en = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       rd_n, wr_n;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_out, m_oe, m_rdata, h1, h2;
    logic       m_en;
    int         m_wage, m_rage;

    always #2 clk = ~clk;

    port_strobe_gen u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr_en(cpu_wr_en),
        .cpu_rd_en(cpu_rd_en), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic exp_strobe(input int age, input int dly);
        return !(age >= dly && age < dly + 2);
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_out = '0; m_oe = '0; m_rdata = '0; h1 = '0; h2 = '0;
        m_en = 1'b0; m_wage = 4; m_rage = 5;
    endtask

    // one cycle: drive, model the edge, compare at negedge
    task automatic step(input logic [1:0] a, input logic w, input logic r,
                        input logic [7:0] d, input logic [7:0] p);
        logic old_en;
        cpu_addr = a; cpu_wr_en = w; cpu_rd_en = r; cpu_wdata = d; pin_in = p;
        @(posedge clk);
        old_en = m_en;
        if (r) begin
            case (a)
                2'd0: m_rdata = h2;
                2'd1: m_rdata = m_oe;
                2'd2: m_rdata = {7'b0, m_en};
                default: m_rdata = '0;
            endcase
        end
        if (w) begin
            case (a)
                2'd0: m_out = d;
                2'd1: m_oe = d;
                2'd2: m_en = d[0];
                default: ;
            endcase
        end
        if (w && a == 2'd0 && old_en) m_wage = 0;
        else if (!old_en)             m_wage = 4;
        else if (m_wage < 4)          m_wage++;
        if (r && a == 2'd0 && old_en) m_rage = 0;
        else if (!old_en)             m_rage = 5;
        else if (m_rage < 5)          m_rage++;
        h2 = h1; h1 = p;
        @(negedge clk);
        chk("R4", "wr_n", int'(wr_n), int'(exp_strobe(m_wage, 2)));
        chk("R5", "rd_n", int'(rd_n), int'(exp_strobe(m_rage, 3)));
        chk("R3", "pin_out", int'(pin_out), int'(m_out));
        chk("R3", "pin_oe", int'(pin_oe), int'(m_oe));
        chk("R6", "cpu_rdata", int'(cpu_rdata), int'(m_rdata));
    endtask

    task automatic idle(input int n, input logic [7:0] p, output int wl, output int rl);
        wl = 0; rl = 0;
        for (int i = 0; i < n; i++) begin
            step(2'd0, 1'b0, 1'b0, 8'h00, p);
            if (!wr_n) wl++;
            if (!rd_n) rl++;
        end
    endtask

    initial begin
        int wl, rl;
        logic [7:0] held;
        void'($urandom(32'h1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_n", int'(rd_n), 1);
        chk("R1", "wr_n", int'(wr_n), 1);
        chk("R1", "pin_out", int'(pin_out), 0);
        chk("R1", "pin_oe", int'(pin_oe), 0);
        chk("R1", "cpu_rdata", int'(cpu_rdata), 0);
        rst = 1'b0;

        // R2: strobes disabled
        step(2'd0, 1'b1, 1'b1, 8'hA5, 8'h00);
        idle(7, 8'h00, wl, rl);
        chk("R2", "low cycles while disabled", wl + rl, 0);
        // R3: direction
        step(2'd1, 1'b1, 1'b0, 8'hF0, 8'h00);
        chk("R3", "pin_oe after write", int'(pin_oe), 8'hF0);

        // enable
        step(2'd2, 1'b1, 1'b0, 8'h01, 8'h00);
        // R4 write strobe
        step(2'd0, 1'b1, 1'b0, 8'h3C, 8'h00);
        chk("R3", "pin_out same edge", int'(pin_out), 8'h3C);
        idle(6, 8'h00, wl, rl);
        chk("R4", "wr_n low cycles", wl, 2);

        // R5/R6 read strobe and data
        idle(3, 8'h5A, wl, rl);
        step(2'd0, 1'b0, 1'b1, 8'h00, 8'h5A);
        chk("R6", "read data", int'(cpu_rdata), 8'h5A);
        held = cpu_rdata;
        idle(6, 8'hC3, wl, rl);
        chk("R5", "rd_n low cycles", rl, 2);
        chk("R6", "rdata unchanged by strobe", int'(cpu_rdata), int'(held));
        // R6 sync latency: pin changes one cycle before read not yet visible
        step(2'd0, 1'b0, 1'b0, 8'h00, 8'h11);
        step(2'd0, 1'b0, 1'b1, 8'h00, 8'h11);
        chk("R6", "two-stage sync latency", int'(cpu_rdata), 8'hC3);
        idle(6, 8'h11, wl, rl);

        // R7 retrigger
        step(2'd0, 1'b1, 1'b0, 8'h01, 8'h11);
        step(2'd0, 1'b0, 1'b0, 8'h00, 8'h11);
        step(2'd0, 1'b1, 1'b0, 8'h02, 8'h11);
        chk("R7", "wr_n high at restart", int'(wr_n), 1);
        idle(6, 8'h11, wl, rl);
        chk("R7", "wr_n low cycles after restart", wl, 2);

        // R8 simultaneous
        step(2'd0, 1'b1, 1'b1, 8'h77, 8'h11);
        idle(7, 8'h11, wl, rl);
        chk("R8", "wr_n low cycles", wl, 2);
        chk("R8", "rd_n low cycles", rl, 2);

        // R9 readback and no strobe
        step(2'd1, 1'b0, 1'b1, 8'h00, 8'h11);
        chk("R9", "read dir", int'(cpu_rdata), 8'hF0);
        step(2'd2, 1'b0, 1'b1, 8'h00, 8'h11);
        chk("R9", "read ctrl", int'(cpu_rdata), 8'h01);
        step(2'd3, 1'b1, 1'b1, 8'hFF, 8'h11);
        chk("R9", "read unused", int'(cpu_rdata), 8'h00);
        idle(7, 8'h11, wl, rl);
        chk("R9", "no strobe on other addresses", wl + rl, 0);

        // R2 abort mid sequence
        step(2'd0, 1'b1, 1'b0, 8'h55, 8'h11);
        step(2'd2, 1'b1, 1'b0, 8'h00, 8'h11);
        idle(6, 8'h11, wl, rl);
        chk("R2", "abort on disable", wl, 0);
        step(2'd2, 1'b1, 1'b0, 8'h01, 8'h11);

        // random mix checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] a;
            a = ($urandom % 8 < 6) ? 2'd0 : 2'($urandom % 4);
            step(a, ($urandom % 4) == 0, ($urandom % 4) == 0,
                 (a == 2'd2) ? (($urandom % 10 == 0) ? 8'h00 : 8'h01) : 8'($urandom),
                 8'($urandom));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule